// File: doc/BRIEF.md
# Bridge System Error Event Reporter

This block gathers error events from a two-port bus bridge and decides whether to pull an active-low system error output. Four causes can be reported. A posted write can see a parity error on the far bus. Delayed write data can be thrown away. A delayed read can be abandoned. A delayed transaction can hit a master timeout. Each reported cause leaves a sticky bit in a status register, so software can find out why the output fired.

Three of the causes can be silenced one at a time through a mask register. The master timeout has no mask bit. Instead, a dedicated enable input from the bridge control register gates it. Over all causes sits a global error-enable input.

The block also keeps one retry counter for delayed writes and one for delayed reads. When a transaction collects 2^LIMIT_LOG2 target retries without completing, the block raises the matching discard event. That discard is reported like any other cause.

Top module: `serr_event_reporter`

## Requirements
- R1: After reset, `serr_n` is 1, the status register reads 0 and the mask register reads 0.
- R2: When `err_en` is 1 and an unmasked cause occurs, `serr_n` is 0 in the cycle after that clock edge. It returns to 1 the cycle after, unless another reported cause occurs.
- R3: While `err_en` is 0, no cause drives `serr_n` low and no status bit is set.
- R4: Mask bits 0, 1 and 2 suppress the parity, write-discard and read-discard causes. A masked cause neither drives the output nor sets status.
- R5: The master timeout is reported only when `err_en` and `mto_en` are both 1. Mask bit 3 is not writable and always reads 0.
- R6: A reported cause sets its status bit. The bit stays set until software writes 1 to it with `reg_sel`=0. If a set and a clear arrive in the same cycle, the set wins.
- R7: A `dw_retry` pulse that brings the write retry count to 2^LIMIT_LOG2 raises the write-discard cause in that cycle and restarts the count from 0.
- R8: A `dr_retry` pulse that brings the read retry count to 2^LIMIT_LOG2 raises the read-discard cause in that cycle and restarts the count from 0.
- R9: A `dw_done` or `dr_done` pulse clears its counter. It overrides a retry pulse in the same cycle.
- R10: With `reg_sel`=0, `reg_rdata` shows status as {timeout, read discard, write discard, parity} from bit 3 down to bit 0. With `reg_sel`=1, it shows the mask in the same bit order. A write with `reg_we`=1 acts on the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_en | input | 1 | Global system error enable |
| mto_en | input | 1 | Master timeout report enable |
| ev_parity | input | 1 | Parity error on posted write, pulse |
| ev_mto | input | 1 | Master timeout on delayed transaction, pulse |
| dw_retry | input | 1 | Delayed write received target retry |
| dw_done | input | 1 | Delayed write completed |
| dr_retry | input | 1 | Delayed read received target retry |
| dr_done | input | 1 | Delayed read completed |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata | input | 4 | Write data (status: write 1 to clear) |
| reg_rdata | output | 4 | Selected register contents |
| serr_n | output | 1 | Active-low system error output |

## Verification
The bench builds the block with CNT_W=5 and LIMIT_LOG2=4, which sets the discard limit at 16 retries. At that limit, random runs reach both discard causes many times over. Directed sequences can also step to exactly one retry before the limit and then across it. Runs of completions between retries cover the counter clear and its precedence over a retry. With the default limit of 2^24, none of this would be reachable.

// File: rtl/serr_event_reporter.sv
module serr_event_reporter #(
  parameter int CNT_W      = 25,
  parameter int LIMIT_LOG2 = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_en,
  input  logic       mto_en,
  input  logic       ev_parity,
  input  logic       ev_mto,
  input  logic       dw_retry,
  input  logic       dw_done,
  input  logic       dr_retry,
  input  logic       dr_done,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  output logic       serr_n
);
  localparam logic [CNT_W-1:0] LAST = (CNT_W'(1) << LIMIT_LOG2) - CNT_W'(1);

  logic [CNT_W-1:0] dw_cnt, dr_cnt;
  logic [3:0] status;
  logic [2:0] mask;
  logic dw_disc, dr_disc;
  logic [3:0] cause, report, st_clr;

  assign dw_disc = dw_retry && !dw_done && (dw_cnt == LAST);
  assign dr_disc = dr_retry && !dr_done && (dr_cnt == LAST);

  assign cause  = {ev_mto, dr_disc, dw_disc, ev_parity};
  assign report = err_en ? (cause & {mto_en, ~mask}) : 4'b0;
  assign st_clr = (reg_we && !reg_sel) ? reg_wdata : 4'b0;

  assign reg_rdata = reg_sel ? {1'b0, mask} : status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dw_cnt <= '0;
    end else if (dw_done || dw_disc) begin
      dw_cnt <= '0;
    end else if (dw_retry) begin
      dw_cnt <= dw_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_cnt <= '0;
    end else if (dr_done || dr_disc) begin
      dr_cnt <= '0;
    end else if (dr_retry) begin
      dr_cnt <= dr_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
      serr_n <= 1'b1;
    end else begin
      status <= (status & ~st_clr) | report;
      serr_n <= ~|report;
      if (reg_we && reg_sel) mask <= reg_wdata[2:0];
    end
  end
endmodule

module serr_event_reporter_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_en,
  input logic             mto_en,
  input logic             ev_parity,
  input logic             ev_mto,
  input logic             dw_done,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [3:0]       reg_wdata,
  input logic             serr_n,
  input logic [3:0]       status,
  input logic [2:0]       mask,
  input logic [CNT_W-1:0] dw_cnt
);
  a_r2_parity_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (err_en && ev_parity && !mask[0]) |=> (!serr_n && status[0]));
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !err_en |=> serr_n);
  a_r4_masked_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[0] && !status[0]) |=> !status[0]);
  a_r5_timeout_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (err_en && mto_en && ev_mto) |=> (!serr_n && status[3]));
  a_r5_timeout_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!mto_en && !status[3]) |=> !status[3]);
  a_r6_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(reg_we && !reg_sel && reg_wdata[0]));
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dw_done |=> (dw_cnt == '0));
endmodule

bind serr_event_reporter serr_event_reporter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_en(err_en), .mto_en(mto_en),
  .ev_parity(ev_parity), .ev_mto(ev_mto), .dw_done(dw_done),
  .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .serr_n(serr_n), .status(status), .mask(mask), .dw_cnt(dw_cnt)
);

// File: tb/sim_serr_event_reporter.sv
module sim_serr_event_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;
  localparam int LIMIT_LOG2 = 4;
  localparam int LIM = 1 << LIMIT_LOG2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_en = 0, mto_en = 0, ev_parity = 0, ev_mto = 0;
  logic dw_retry = 0, dw_done = 0, dr_retry = 0, dr_done = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic serr_n;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  logic [3:0] m_status = '0;
  logic [2:0] m_mask = '0;
  int m_dwc = 0, m_drc = 0;
  bit exp_serr_n = 1;

  serr_event_reporter #(.CNT_W(CNT_W), .LIMIT_LOG2(LIMIT_LOG2)) u0 (
    .clk(clk), .rst_n(rst_n), .err_en(err_en), .mto_en(mto_en),
    .ev_parity(ev_parity), .ev_mto(ev_mto), .dw_retry(dw_retry),
    .dw_done(dw_done), .dr_retry(dr_retry), .dr_done(dr_done),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .serr_n(serr_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit hits_limit(int cnt, bit retry, bit done);
    return retry && !done && (cnt == LIM - 1);
  endfunction

  function automatic int next_cnt(int cnt, bit retry, bit done);
    if (done || hits_limit(cnt, retry, done)) return 0;
    return retry ? cnt + 1 : cnt;
  endfunction

  function automatic logic [3:0] gated(bit en, bit men, logic [2:0] msk, logic [3:0] c);
    return en ? (c & {men, ~msk}) : 4'b0;
  endfunction

  task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic cyc(string tag, bit e, bit me, bit par, bit mto, bit dwr, bit dwd,
                     bit drr, bit drd, bit we, bit sel, logic [3:0] wd);
    logic [3:0] c, g;
    @(negedge clk);
    err_en = e; mto_en = me; ev_parity = par; ev_mto = mto;
    dw_retry = dwr; dw_done = dwd; dr_retry = drr; dr_done = drd;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    c = {mto, hits_limit(m_drc, drr, drd), hits_limit(m_dwc, dwr, dwd), par};
    g = gated(e, me, m_mask, c);
    exp_serr_n = ~|g;
    if (we && !sel) m_status = m_status & ~wd;
    m_status = m_status | g;
    if (we && sel) m_mask = wd[2:0];
    m_dwc = next_cnt(m_dwc, dwr, dwd);
    m_drc = next_cnt(m_drc, drr, drd);
    @(posedge clk);
    #1;
    check(tag, "serr_n", {3'b0, serr_n}, {3'b0, exp_serr_n});
    check(tag, "rdata", reg_rdata, sel ? {1'b0, m_mask} : m_status);
  endtask

  task automatic idle(string tag, bit sel);
    cyc(tag, 1, 1, 0, 0, 0, 0, 0, 0, 0, sel, 4'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "serr_n reset", {3'b0, serr_n}, 4'h1);
    check("R1", "status reset", reg_rdata, 4'h0);
    idle("R1", 1);

    // mask write: bit 3 not writable
    cyc("R5", 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 4'hF);
    // masked parity ignored
    cyc("R4", 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 4'h0);
    idle("R4", 0);
    cyc("R10", 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 4'h0);
    // global enable off
    cyc("R3", 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 4'h0);
    idle("R3", 0);
    // reported parity, one-cycle pulse
    cyc("R2", 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 4'h0);
    idle("R2", 0);
    // timeout with full mask, then with mto_en low
    cyc("R5", 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 4'h7);
    cyc("R5", 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 4'h0);
    cyc("R5", 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 4'h8);
    cyc("R5", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 4'h0);
    cyc("R10", 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 4'h0);
    // set beats clear, then clear alone
    cyc("R6", 1, 1, 1, 0, 0, 0, 0, 0, 1, 0, 4'h1);
    cyc("R6", 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 4'h1);
    idle("R6", 0);
    // write discard at the limit
    for (int i = 0; i < LIM - 1; i++) cyc("R7", 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 4'h0);
    cyc("R7", 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 4'h0);
    idle("R7", 0);
    // done clears, done wins over retry, then read discard
    for (int i = 0; i < 10; i++) cyc("R9", 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 4'h0);
    cyc("R9", 1, 1, 0, 0, 0, 0, 1, 1, 0, 0, 4'h0);
    for (int i = 0; i < LIM - 1; i++) cyc("R9", 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 4'h0);
    cyc("R8", 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 4'h0);
    cyc("R8", 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 4'hF);

    for (int i = 0; i < 4000; i++) begin
      cyc("R2", ($urandom % 8) != 0, ($urandom % 4) != 0,
          ($urandom % 16) == 0, ($urandom % 16) == 0,
          ($urandom % 2) == 0, ($urandom % 48) == 0,
          ($urandom % 2) == 0, ($urandom % 48) == 0,
          ($urandom % 8) == 0, ($urandom % 3) == 0, 4'($urandom));
    end
    summary();
  end
endmodule